// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the host-facing access path into a display controller's register space. The host drives a 16-bit bus cycle qualified by a strobe, a read/write flag and a command/data select. A command write latches an 8-bit register index. A data write updates the register that the index points at and then moves the index forward by two, which walks a word-aligned map. A data read returns the selected byte on the next edge and moves the index forward by one.

Three addresses are stream ports. On a write to a stream port the index does not move, so a burst can pour data into one location. Two of these ports front internal byte tables. Each table has its own pointer, which can be loaded through a neighbouring register and steps after every access. The third stream port accepts and discards pixel traffic.

A discard counter, loaded from a side input, makes the port skip a given number of host cycles. It is used to drop dummy bus cycles after a mode change. The block also holds a few sample registers: a read-only revision byte, a 10-bit value split over two addresses, and an event flag byte that the host clears by writing zeros.

Top module: `regidx_port`

## Requirements
- R1: A command write (strobe high, `host_dsel`=0, `host_write`=1) loads `host_wdata[7:0]` into the register index and changes no register. A command read returns the byte at the current index and leaves the index unchanged.
- R2: A data write moves the index up by 2, wrapping modulo 256. The exception is an index of 0x90, 0x5A or 0xB8 (the stream ports), where the index does not move.
- R3: A data read places `{8'h00, byte}` for the current index on `host_rdata` at the next clock edge. It then moves the index up by 1. `host_rdata` holds its value between reads.
- R4: Asserting `skip_load` loads `skip_count` into the discard counter. While the counter is non-zero, each host cycle decrements it and has no other effect: a write changes nothing, the index does not move, and a read returns 0.
- R5: Address 0xB6 holds an 8-bit gamma pointer, which can be written and read. Address 0xB8 reads or writes the byte at that pointer in a 256-entry table. The pointer then steps by 1 and wraps from 255 to 0.
- R6: Address 0x58 loads the filter pointer from `host_wdata[4:0]`. Address 0x5A accesses a 32-entry byte table at that pointer, and the pointer then steps by 1. When the pointer has reached 32, accesses are ignored, reads return 0 and the pointer stays at 32. Reading 0x58 returns the pointer.
- R7: A bit of the flag byte at 0xF6 is set whenever the matching `flag_event` bit is high. A write to 0xF6 ANDs `host_wdata[7:0]` into the flags; an event bit in the same cycle still sets its flag.
- R8: Reading address 0x00 returns 0xA5. Writes to address 0x00 have no effect.
- R9: A 10-bit value is written in two parts. Address 0x6C writes bits 7:0. Address 0x6E writes bits 9:8 from `host_wdata[1:0]`. Each write keeps the other part. Reading 0x6E returns bits 9:8 in bits 1:0.
- R10: Reads of any other index, including 0x90 and odd indices, return 0. Writes to them have no effect.
- R11: After reset, the following are all zero: the index, the discard counter, both table pointers, both tables, the flags, the 10-bit value and `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host cycle strobe, one clock per cycle |
| host_write | input | 1 | 1 = write cycle, 0 = read cycle |
| host_dsel | input | 1 | 1 = data cycle, 0 = command cycle |
| host_wdata | input | 16 | Write data or index value |
| host_rdata | output | 16 | Read result, registered |
| skip_load | input | 1 | Loads the discard counter |
| skip_count | input | SKIP_W | Number of host cycles to discard |
| flag_event | input | 8 | Per-bit flag set requests |

## Verification
A read result appears on `host_rdata` at the same edge that accepts the read strobe. The bench therefore samples it one nanosecond after that edge, well before the next falling edge, where it drives new inputs. Index moves, pointer steps, table writes and flag changes all take effect at the strobe edge. They can only be seen through a later read, so every check compares the result of that later read with a bench model. The model is updated in host-cycle order, and each expected read value is computed from the model state before the cycle is applied.

// File: rtl/regidx_pkg.sv
package regidx_pkg;
   localparam int REG_AW = 8;
   localparam int BUS_W  = 16;

   localparam logic [REG_AW-1:0] ADR_REV   = 8'h00;
   localparam logic [REG_AW-1:0] ADR_FPTR  = 8'h58;
   localparam logic [REG_AW-1:0] ADR_FDAT  = 8'h5A;
   localparam logic [REG_AW-1:0] ADR_WLO   = 8'h6C;
   localparam logic [REG_AW-1:0] ADR_WHI   = 8'h6E;
   localparam logic [REG_AW-1:0] ADR_PIX   = 8'h90;
   localparam logic [REG_AW-1:0] ADR_GPTR  = 8'hB6;
   localparam logic [REG_AW-1:0] ADR_GDAT  = 8'hB8;
   localparam logic [REG_AW-1:0] ADR_FLAG  = 8'hF6;
   localparam logic [7:0]        REV_VALUE = 8'hA5;

   // Ports where a write burst keeps the index in place
   function automatic logic is_stream(input logic [REG_AW-1:0] a);
      return (a == ADR_PIX) || (a == ADR_FDAT) || (a == ADR_GDAT);
   endfunction
endpackage

// File: rtl/regidx_seq.sv
module regidx_seq
   import regidx_pkg::*;
#(
   parameter int SKIP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic              cyc_write,
   input  logic              cyc_dsel,
   input  logic [REG_AW-1:0] cyc_data,
   input  logic              disc_load,
   input  logic [SKIP_W-1:0] disc_val,
   output logic [REG_AW-1:0] idx_q,
   output logic              disc_busy
);
   logic [SKIP_W-1:0] cnt_q;

   assign disc_busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else begin
         if (disc_load)
            cnt_q <= disc_val;
         else if (cyc_valid && disc_busy)
            cnt_q <= cnt_q - 1'b1;

         if (cyc_valid && !disc_busy) begin
            if (!cyc_dsel) begin
               if (cyc_write) idx_q <= cyc_data;
            end else if (cyc_write) begin
               if (!is_stream(idx_q)) idx_q <= idx_q + REG_AW'(2);
            end else begin
               idx_q <= idx_q + REG_AW'(1);
            end
         end
      end
   end

   assert_cmd_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !disc_busy && !cyc_dsel && cyc_write) |=> (idx_q == $past(cyc_data)));

   assert_stream_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !disc_busy && cyc_dsel && cyc_write && is_stream(idx_q)) |=> $stable(idx_q));

   assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && !disc_busy && cyc_dsel && !cyc_write) |=> (idx_q == REG_AW'($past(idx_q) + 1)));

   assert_discard_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && disc_busy && !disc_load) |=>
         ((cnt_q == SKIP_W'($past(cnt_q) - 1)) && $stable(idx_q)));
endmodule

// File: rtl/regidx_table.sv
module regidx_table #(
   parameter int DEPTH   = 256,
   parameter int DW      = 8,
   parameter bit BOUNDED = 1'b0,
   localparam int AW     = $clog2(DEPTH),
   localparam int IW     = BOUNDED ? AW + 1 : AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_set,
   input  logic [AW-1:0] ptr_val,
   input  logic          acc,
   input  logic          acc_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [IW-1:0] ptr_q
);
   logic [DW-1:0] mem_q [DEPTH];
   logic          in_rng;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("regidx_table: DEPTH must be a power of two");
   end
   if (AW > 8 || AW < 1) begin : g_bad_aw
      $error("regidx_table: pointer must fit in one byte");
   end

   if (BOUNDED) begin : g_bounded
      assign in_rng = (ptr_q < IW'(DEPTH));

      assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ptr_q <= IW'(DEPTH));
   end else begin : g_wrap
      assign in_rng = 1'b1;
   end

   assign rdata = in_rng ? mem_q[ptr_q[AW-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (acc && acc_wr && in_rng) mem_q[ptr_q[AW-1:0]] <= wdata;
         if (ptr_set)
            ptr_q <= IW'(ptr_val);
         else if (acc && in_rng)
            ptr_q <= ptr_q + 1'b1;
      end
   end

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_rng && !ptr_set) |=> (ptr_q == IW'($past(ptr_q) + 1)));
endmodule

// File: rtl/regidx_port.sv
module regidx_port
   import regidx_pkg::*;
#(
   parameter int SKIP_W      = 8,
   parameter int GAMMA_DEPTH = 256,
   parameter int FILT_DEPTH  = 32,
   parameter int WIN_W       = 10,
   localparam int GAW        = $clog2(GAMMA_DEPTH),
   localparam int FAW        = $clog2(FILT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   input  logic              host_write,
   input  logic              host_dsel,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   input  logic              skip_load,
   input  logic [SKIP_W-1:0] skip_count,
   input  logic [7:0]        flag_event
);
   if (WIN_W < 9 || WIN_W > 16) begin : g_bad_win
      $error("regidx_port: WIN_W must lie in 9..16");
   end

   logic [REG_AW-1:0] idx;
   logic              busy, live, dacc, dwr;
   logic [7:0]        g_rd, f_rd, rd_val, flag_q;
   logic [GAW-1:0]    g_ptr;
   logic [FAW:0]      f_ptr;
   logic [WIN_W-1:0]  win_q;
   logic              unused_hi;

   assign unused_hi = ^host_wdata[15:8];
   assign live      = host_valid && !busy;
   assign dacc      = live && host_dsel;
   assign dwr       = dacc && host_write;

   regidx_seq #(.SKIP_W(SKIP_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cyc_valid(host_valid), .cyc_write(host_write), .cyc_dsel(host_dsel),
      .cyc_data(host_wdata[REG_AW-1:0]),
      .disc_load(skip_load), .disc_val(skip_count),
      .idx_q(idx), .disc_busy(busy)
   );

   regidx_table #(.DEPTH(GAMMA_DEPTH), .DW(8), .BOUNDED(1'b0)) u_gamma (
      .clk(clk), .rst_n(rst_n),
      .ptr_set(dwr && idx == ADR_GPTR), .ptr_val(host_wdata[GAW-1:0]),
      .acc(dacc && idx == ADR_GDAT), .acc_wr(host_write),
      .wdata(host_wdata[7:0]), .rdata(g_rd), .ptr_q(g_ptr)
   );

   regidx_table #(.DEPTH(FILT_DEPTH), .DW(8), .BOUNDED(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n),
      .ptr_set(dwr && idx == ADR_FPTR), .ptr_val(host_wdata[FAW-1:0]),
      .acc(dacc && idx == ADR_FDAT), .acc_wr(host_write),
      .wdata(host_wdata[7:0]), .rdata(f_rd), .ptr_q(f_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         flag_q <= '0;
      end else begin
         if (dwr && idx == ADR_WLO) win_q[7:0] <= host_wdata[7:0];
         if (dwr && idx == ADR_WHI) win_q[WIN_W-1:8] <= host_wdata[WIN_W-9:0];
         flag_q <= ((dwr && idx == ADR_FLAG) ? (flag_q & host_wdata[7:0]) : flag_q)
                   | flag_event;
      end
   end

   always_comb begin
      case (idx)
         ADR_REV:  rd_val = REV_VALUE;
         ADR_FPTR: rd_val = 8'(f_ptr);
         ADR_FDAT: rd_val = f_rd;
         ADR_WLO:  rd_val = win_q[7:0];
         ADR_WHI:  rd_val = 8'(win_q[WIN_W-1:8]);
         ADR_GPTR: rd_val = 8'(g_ptr);
         ADR_GDAT: rd_val = g_rd;
         ADR_FLAG: rd_val = flag_q;
         default:  rd_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (host_valid && !host_write)
         host_rdata <= live ? {8'h00, rd_val} : 16'h0000;
   end

   assert_rev_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !host_write && idx == ADR_REV) |=> (host_rdata == 16'h00A5));

   assert_skip_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && busy) |=> (host_rdata == 16'h0000));

   assert_flag_and_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && idx == ADR_FLAG && flag_event == 8'h00) |=>
         (flag_q == $past(flag_q & host_wdata[7:0])));

   assert_win_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && idx == ADR_WHI) |=> (win_q[7:0] == $past(win_q[7:0])));
endmodule

// File: tb/sim_regidx_port.sv
module sim_regidx_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0, host_write = 1'b0, host_dsel = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        skip_load = 1'b0;
   logic [7:0]  skip_count = '0;
   logic [7:0]  flag_event = '0;

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   logic [7:0] m_idx, m_gp, m_flag;
   logic [7:0] m_g [256];
   logic [7:0] m_f [32];
   int         m_fp, m_skip;
   logic [9:0] m_win;

   always #2 clk = ~clk;

   regidx_port u0 (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_dsel(host_dsel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .skip_load(skip_load), .skip_count(skip_count), .flag_event(flag_event)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] mdl_read();
      case (m_idx)
         8'h00: return 8'hA5;
         8'h58: return 8'(m_fp);
         8'h5A: return (m_fp < 32) ? m_f[m_fp] : 8'h00;
         8'h6C: return m_win[7:0];
         8'h6E: return {6'b0, m_win[9:8]};
         8'hB6: return m_gp;
         8'hB8: return m_g[m_gp];
         8'hF6: return m_flag;
         default: return 8'h00;
      endcase
   endfunction

   task automatic mdl_reset();
      m_idx = 0; m_gp = 0; m_flag = 0; m_fp = 0; m_skip = 0; m_win = 0;
      for (int i = 0; i < 256; i++) m_g[i] = 0;
      for (int i = 0; i < 32; i++) m_f[i] = 0;
   endtask

   // one host cycle; read results checked against the model
   task automatic host(input logic sel, input logic wr, input logic [15:0] d,
                       input logic [7:0] ev, input string tag);
      logic [15:0] exp;
      exp = {8'h00, mdl_read()};
      if (m_skip > 0) begin
         m_skip--;
         exp = 16'h0000;
      end else if (!sel) begin
         if (wr) m_idx = d[7:0];
      end else if (wr) begin
         case (m_idx)
            8'h58: m_fp = int'(d[4:0]);
            8'h5A: if (m_fp < 32) begin m_f[m_fp] = d[7:0]; m_fp++; end
            8'h6C: m_win[7:0] = d[7:0];
            8'h6E: m_win[9:8] = d[1:0];
            8'hB6: m_gp = d[7:0];
            8'hB8: begin m_g[m_gp] = d[7:0]; m_gp = m_gp + 8'd1; end
            8'hF6: m_flag = m_flag & d[7:0];
            default: ;
         endcase
         if (m_idx != 8'h90 && m_idx != 8'h5A && m_idx != 8'hB8) m_idx = m_idx + 8'd2;
      end else begin
         if (m_idx == 8'h5A && m_fp < 32) m_fp++;
         if (m_idx == 8'hB8) m_gp = m_gp + 8'd1;
         m_idx = m_idx + 8'd1;
      end
      m_flag = m_flag | ev;

      @(negedge clk);
      host_valid = 1'b1; host_dsel = sel; host_write = wr; host_wdata = d; flag_event = ev;
      @(posedge clk);
      #1;
      host_valid = 1'b0; flag_event = 8'h00;
      if (!wr) check(tag, host_rdata, exp);
   endtask

   task automatic skip(input int n);
      @(negedge clk);
      skip_load = 1'b1; skip_count = 8'(n);
      @(posedge clk);
      #1;
      skip_load = 1'b0;
      m_skip = n;
   endtask

   task automatic cmd(input logic [7:0] a, input string tag);
      host(1'b0, 1'b1, {8'h00, a}, 8'h00, tag);
   endtask

   task automatic wdat(input logic [15:0] d, input string tag);
      host(1'b1, 1'b1, d, 8'h00, tag);
   endtask

   task automatic rdat(input string tag);
      host(1'b1, 1'b0, 16'h0, 8'h00, tag);
   endtask

   function automatic logic [7:0] pick_addr();
      case ($urandom % 11)
         0: return 8'h00;
         1: return 8'h58;
         2: return 8'h5A;
         3: return 8'h6C;
         4: return 8'h6E;
         5: return 8'hB6;
         6: return 8'hB8;
         7: return 8'hF6;
         8: return 8'h90;
         9: return 8'h6A;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      mdl_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11 rdata after reset", host_rdata, 16'h0000);

      // R8 / R11: index starts at 0, revision constant; R1 command read keeps index
      host(1'b0, 1'b0, 16'h0, 8'h00, "R8 revision via command read");
      host(1'b0, 1'b0, 16'h0, 8'h00, "R1 command read keeps index");
      wdat(16'h0033, "R8 write to revision");
      cmd(8'h00, "R1");
      rdat("R8 revision unchanged");
      rdat("R10 odd index reads zero");

      // R9 split value and R2 step by two
      cmd(8'h6C, "R1");
      wdat(16'hFF55, "R9");
      wdat(16'h00FF, "R2 index stepped to high part");
      cmd(8'h6C, "R1");
      rdat("R9 low part");
      cmd(8'h6E, "R1");
      rdat("R9 high part");
      cmd(8'h6C, "R1");
      wdat(16'h00AA, "R9");
      cmd(8'h6E, "R1");
      rdat("R9 high part kept");

      // R5 gamma pointer wrap and stream hold
      cmd(8'hB6, "R1");
      wdat(16'h00FE, "R5");
      wdat(16'h0011, "R5"); wdat(16'h0022, "R5"); wdat(16'h0033, "R2 stream hold");
      cmd(8'hB6, "R1");
      rdat("R5 gamma pointer wrapped");
      cmd(8'hB6, "R1"); wdat(16'h00FE, "R5");
      cmd(8'hB8, "R1"); rdat("R5 gamma entry 0xFE");
      cmd(8'hB8, "R1"); rdat("R5 gamma entry 0xFF");
      cmd(8'hB8, "R1"); rdat("R5 gamma entry 0x00");

      // R6 filter bound
      cmd(8'h58, "R1");
      wdat(16'h003E, "R6 masked pointer");
      wdat(16'h00A1, "R6"); wdat(16'h00B2, "R6"); wdat(16'h00C3, "R6 ignored at 32");
      cmd(8'h58, "R1"); rdat("R6 pointer stuck at 32");
      cmd(8'h5A, "R1"); rdat("R6 out-of-range read zero");
      cmd(8'h58, "R1"); wdat(16'h001E, "R6");
      cmd(8'h5A, "R1"); rdat("R6 entry 30");
      cmd(8'h58, "R1"); wdat(16'h001F, "R6");
      cmd(8'h5A, "R1"); rdat("R6 entry 31");

      // R7 flags
      host(1'b0, 1'b1, 16'h00F6, 8'h0F, "R7 event set");
      rdat("R7 flags set");
      cmd(8'hF6, "R1");
      wdat(16'h0005, "R7");
      cmd(8'hF6, "R1");
      rdat("R7 flags after AND");
      cmd(8'hF6, "R1");
      host(1'b1, 1'b1, 16'h0000, 8'h80, "R7 event beats clear");
      cmd(8'hF6, "R1");
      rdat("R7 event set during clear");

      // R4 discard counter
      cmd(8'h6C, "R1");
      skip(3);
      cmd(8'h00, "R4 swallowed command");
      wdat(16'h0077, "R4 swallowed write");
      rdat("R4 swallowed read returns zero");
      rdat("R4 index and value untouched");

      // R10 unmapped
      cmd(8'h40, "R1"); wdat(16'h00EE, "R10");
      cmd(8'h40, "R1"); rdat("R10 unmapped reads zero");
      cmd(8'h90, "R1"); wdat(16'h1234, "R10"); wdat(16'h5678, "R2 pixel port hold");
      rdat("R10 pixel port reads zero");
      rdat("R2 R3 index moved by one after read");

      // constrained random mix
      for (int k = 0; k < 3000; k++) begin
         int r;
         logic [7:0] ev;
         r  = int'($urandom % 100);
         ev = (($urandom % 10) == 0) ? 8'($urandom) : 8'h00;
         if (r < 3)
            skip(int'($urandom % 4) + 1);
         else if (r < 30)
            host(1'b0, 1'b1, {8'($urandom), pick_addr()}, ev, "R1 random command");
         else if (r < 60)
            host(1'b1, 1'b1, 16'($urandom), ev, "R2 random write");
         else if (r < 93)
            host(1'b1, 1'b0, 16'($urandom), ev, "R3 random read");
         else
            host(1'b0, 1'b0, 16'($urandom), ev, "R1 random command read");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule